// File: doc/BRIEF.md
# SPI Command Framer with Input CRC

This block turns one command request into the complete transmit frame that a host pushes into a multi-channel delta-sigma ADC over SPI. A request names one of four operations and carries a 5-bit register address and 16 bits of write data. The operations are a no-op poll, a soft reset, a one-register read and a one-register write. The framer builds a 16-bit command word from the request. It lays out 24-bit words, sending each word's upper two bytes most significant byte first, followed by a zero byte. It protects the command part of the frame with a CRC-16, seeded with all ones and using polynomial 0x1021.

The frame holds NUM_CH+2 words, so the ADC clocks out its own response frame of the same length while the command is shifted in. The bytes leave one at a time on a valid/ready stream towards the SPI shifter. A new request is taken only while the framer is idle. A one-cycle completion pulse marks the end of each frame.

Top module: `spi_cmd_framer`

## Requirements
- R1: After reset, req_ready is 1, byte_valid is 0 and frame_done is 0.
- R2: req_kind 0 (poll) produces command word 0x0000 in bytes 0 and 1.
- R3: req_kind 1 (soft reset) produces command word 0x0011 in bytes 0 and 1.
- R4: req_kind 2 (read) produces 0xA000 with req_addr in bits 11:7 and 0 in bits 6:0, in bytes 0 and 1.
- R5: req_kind 3 (write) produces 0x6000 with req_addr in bits 11:7 and 0 in bits 6:0, in bytes 0 and 1, and places req_data in bytes 3 (high) and 4 (low).
- R6: The third byte of every 24-bit word (byte index modulo 3 equal to 2) is 0x00.
- R7: For kinds 0 to 2, bytes 3 and 4 hold the CRC, high byte first, taken over frame bytes 0 to 2.
- R8: For kind 3, bytes 6 and 7 hold the CRC, high byte first, taken over frame bytes 0 to 5.
- R9: Each frame is exactly 3*(NUM_CH+2) bytes, and every byte after the CRC word is 0x00.
- R10: A request is accepted only while req_ready is 1. Once a request is accepted, byte_valid rises and req_ready falls on the next cycle. A request raised while busy neither alters the frame in flight nor starts another frame.
- R11: frame_done is high for exactly one cycle, on the cycle after the last byte handshake. In that cycle req_ready is already 1 and byte_valid is 0.
- R12: While byte_valid is 1 and byte_ready is 0, the same byte is held on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Framer idle, request will be taken |
| req_kind | input | 2 | 0 poll, 1 soft reset, 2 read, 3 write |
| req_addr | input | 5 | Register address |
| req_data | input | 16 | Write data (used by kind 3 only) |
| byte_valid | output | 1 | Frame byte on byte_data |
| byte_ready | input | 1 | Shifter takes the byte this cycle |
| byte_data | output | 8 | Current frame byte |
| frame_done | output | 1 | One-cycle pulse after the final byte |

## Verification
On every cycle, the assertions check the stream mechanics. These are the hold-under-stall rule, the zero low byte of each word, the frame byte count at completion, the single-cycle done pulse and the busy state that follows an accepted request. The command encodings, the CRC values and their position, which moves with the command kind, and the zero tail can only be shown by the bench's comparisons. The bench compares each captured frame against a frame built from the requirements, for directed and random requests. A request raised while a frame is in flight is also tested there, since its harmlessness shows only in the finished frame and the idle cycles after it.

// File: rtl/spi_cmd_framer_pkg.sv
package spi_cmd_framer_pkg;

   typedef enum logic [1:0] {
      KIND_POLL  = 2'd0,
      KIND_SRST  = 2'd1,
      KIND_READ  = 2'd2,
      KIND_WRITE = 2'd3
   } cmd_kind_e;

   localparam int          ADDR_W     = 5;
   localparam logic [15:0] OP_POLL    = 16'h0000;
   localparam logic [15:0] OP_SRST    = 16'h0011;
   localparam logic [3:0]  OP_READ_HI = 4'hA;
   localparam logic [3:0]  OP_WRITE_HI = 4'h6;
   localparam int          WORD_BYTES = 3;

   // one byte of CRC-16, MSB first, non-reflected
   function automatic logic [15:0] crc_step(input logic [15:0] c_in,
                                             input logic [7:0]  b,
                                             input logic [15:0] poly);
      logic [15:0] c;
      c = c_in ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) begin
         c = c[15] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/xfr_cmd_encode.sv
module xfr_cmd_encode
   import spi_cmd_framer_pkg::*;
(
   input  cmd_kind_e          kind,
   input  logic [ADDR_W-1:0]  addr,
   output logic [15:0]        cmd
);
   always_comb begin
      unique case (kind)
         KIND_POLL:  cmd = OP_POLL;
         KIND_SRST:  cmd = OP_SRST;
         KIND_READ:  cmd = {OP_READ_HI, addr, 7'd0};
         KIND_WRITE: cmd = {OP_WRITE_HI, addr, 7'd0};
         default:    cmd = OP_POLL;
      endcase
   end
endmodule

// File: rtl/xfr_crc16.sv
module xfr_crc16
   import spi_cmd_framer_pkg::*;
#(
   parameter logic [15:0] POLY   = 16'h1021,
   parameter logic [15:0] SEED   = 16'hFFFF,
   parameter int          NBYTES = 6
) (
   input  logic [8*NBYTES-1:0] msg,
   input  logic                full_len,
   output logic [15:0]         crc
);
   localparam int SHORT_LEN = NBYTES / 2;

   logic [15:0] stage [NBYTES+1];

   assign stage[0] = SEED;

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign stage[b+1] = crc_step(stage[b], msg[8*(NBYTES-b)-1 -: 8], POLY);
   end

   assign crc = full_len ? stage[NBYTES] : stage[SHORT_LEN];
endmodule

// File: rtl/xfr_byte_seq.sv
module xfr_byte_seq #(
   parameter int NUM_WORDS = 6,
   localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              take,
   output logic              busy,
   output logic [WIDX_W-1:0] word_idx,
   output logic [1:0]        byte_pos,
   output logic              done
);
   localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         word_idx <= '0;
         byte_pos <= 2'd0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy     <= 1'b1;
            word_idx <= '0;
            byte_pos <= 2'd0;
         end else if (busy && take) begin
            if (byte_pos == 2'd2) begin
               byte_pos <= 2'd0;
               if (word_idx == LAST_WORD) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  word_idx <= word_idx + 1'b1;
               end
            end else begin
               byte_pos <= byte_pos + 2'd1;
            end
         end
      end
   end
endmodule

// File: rtl/spi_cmd_framer.sv
module spi_cmd_framer
   import spi_cmd_framer_pkg::*;
#(
   parameter int          NUM_CH   = 4,
   parameter logic [15:0] CRC_POLY = 16'h1021,
   parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [1:0]  req_kind,
   input  logic [4:0]  req_addr,
   input  logic [15:0] req_data,
   output logic        byte_valid,
   input  logic        byte_ready,
   output logic [7:0]  byte_data,
   output logic        frame_done
);
   localparam int FRAME_WORDS = NUM_CH + 2;
   localparam int WIDX_W      = $clog2(FRAME_WORDS);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
      $error("spi_cmd_framer: NUM_CH must lie in 1..32");
   end

   cmd_kind_e         kind;
   logic [15:0]       cmd;
   logic [15:0]       crc;
   logic              is_write;
   logic              accept;
   logic              busy;
   logic [WIDX_W-1:0] word_idx;
   logic [1:0]        byte_pos;
   logic [15:0]       w0_q, w1_q, w2_q;
   logic [15:0]       cur_word;

   assign kind     = cmd_kind_e'(req_kind);
   assign is_write = (kind == KIND_WRITE);
   assign accept   = req_valid && !busy;

   xfr_cmd_encode u_enc (
      .kind (kind),
      .addr (req_addr),
      .cmd  (cmd)
   );

   xfr_crc16 #(
      .POLY   (CRC_POLY),
      .SEED   (CRC_SEED),
      .NBYTES (2 * WORD_BYTES)
   ) u_crc (
      .msg      ({cmd, 8'h00, req_data, 8'h00}),
      .full_len (is_write),
      .crc      (crc)
   );

   xfr_byte_seq #(
      .NUM_WORDS (FRAME_WORDS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .take     (byte_ready),
      .busy     (busy),
      .word_idx (word_idx),
      .byte_pos (byte_pos),
      .done     (frame_done)
   );

   // payload words captured once per accepted request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w0_q <= '0;
         w1_q <= '0;
         w2_q <= '0;
      end else if (accept) begin
         w0_q <= cmd;
         w1_q <= is_write ? req_data : crc;
         w2_q <= is_write ? crc : 16'h0000;
      end
   end

   always_comb begin
      if (word_idx == WIDX_W'(0))      cur_word = w0_q;
      else if (word_idx == WIDX_W'(1)) cur_word = w1_q;
      else if (word_idx == WIDX_W'(2)) cur_word = w2_q;
      else                             cur_word = 16'h0000;
   end

   always_comb begin
      unique case (byte_pos)
         2'd0:    byte_data = cur_word[15:8];
         2'd1:    byte_data = cur_word[7:0];
         default: byte_data = 8'h00;
      endcase
   end

   assign req_ready  = !busy;
   assign byte_valid = busy;
endmodule

// File: rtl/spi_cmd_framer_chk.sv
module spi_cmd_framer_chk #(
   parameter int NUM_CH = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       byte_valid,
   input logic       byte_ready,
   input logic [7:0] byte_data,
   input logic       frame_done
);
   localparam int FRAME_BYTES = 3 * (NUM_CH + 2);
   localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

   logic [CNT_W-1:0] hs_cnt;
   logic [1:0]       pos_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_cnt <= '0;
         pos_c  <= 2'd0;
      end else if (req_valid && req_ready) begin
         hs_cnt <= '0;
         pos_c  <= 2'd0;
      end else if (byte_valid && byte_ready) begin
         hs_cnt <= hs_cnt + 1'b1;
         pos_c  <= (pos_c == 2'd2) ? 2'd0 : pos_c + 2'd1;
      end
   end

   assert_hold_on_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

   assert_low_byte_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && pos_c == 2'd2) |-> (byte_data == 8'h00));

   assert_frame_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (hs_cnt == CNT_W'(FRAME_BYTES)));

   assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (byte_valid && !req_ready));
endmodule

bind spi_cmd_framer spi_cmd_framer_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .byte_valid (byte_valid),
   .byte_ready (byte_ready),
   .byte_data  (byte_data),
   .frame_done (frame_done)
);

// File: tb/spi_cmd_framer_tb.sv
module spi_cmd_framer_tb;
   localparam int NCH = 4;
   localparam int FB  = 3 * (NCH + 2);

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic        req_ready;
   logic [1:0]  req_kind;
   logic [4:0]  req_addr;
   logic [15:0] req_data;
   logic        byte_valid;
   logic        byte_ready;
   logic [7:0]  byte_data;
   logic        frame_done;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   logic [7:0] exp_b [FB];
   logic [7:0] got_b [FB];

   always #4 clk = ~clk;

   spi_cmd_framer #(.NUM_CH(NCH)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
      .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
      .frame_done(frame_done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bitwise CRC-16, feedback formulation
   function automatic logic [15:0] ref_crc(input logic [47:0] msg, input int nbytes);
      logic [15:0] c = 16'hFFFF;
      logic        fb;
      for (int i = 0; i < nbytes * 8; i++) begin
         fb = c[15] ^ msg[47 - i];
         c  = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   task automatic build_exp(input logic [1:0] kind, input logic [4:0] addr,
                            input logic [15:0] data);
      logic [15:0] cmd;
      logic [15:0] crc;
      case (kind)
         2'd0: cmd = 16'h0000;
         2'd1: cmd = 16'h0011;
         2'd2: cmd = 16'hA000 | (16'(addr) << 7);
         default: cmd = 16'h6000 | (16'(addr) << 7);
      endcase
      for (int i = 0; i < FB; i++) exp_b[i] = 8'h00;
      exp_b[0] = cmd[15:8];
      exp_b[1] = cmd[7:0];
      if (kind == 2'd3) begin
         crc = ref_crc({cmd, 8'h00, data, 8'h00}, 6);
         exp_b[3] = data[15:8];
         exp_b[4] = data[7:0];
         exp_b[6] = crc[15:8];
         exp_b[7] = crc[7:0];
      end else begin
         crc = ref_crc({cmd, 8'h00, 24'h000000}, 3);
         exp_b[3] = crc[15:8];
         exp_b[4] = crc[7:0];
      end
   endtask

   function automatic string tag_of(input logic [1:0] kind, input int i);
      if (i < 2) begin
         case (kind)
            2'd0: return "R2 command";
            2'd1: return "R3 command";
            2'd2: return "R4 command";
            default: return "R5 command";
         endcase
      end
      if (i % 3 == 2) return "R6 low byte";
      if (kind == 2'd3 && (i == 3 || i == 4)) return "R5 data";
      if (kind == 2'd3 && (i == 6 || i == 7)) return "R8 crc";
      if (kind != 2'd3 && (i == 3 || i == 4)) return "R7 crc";
      return "R9 zero tail";
   endfunction

   task automatic run_frame(input logic [1:0] kind, input logic [4:0] addr,
                            input logic [15:0] data, input bit poke_busy);
      int cnt = 0;
      int cyc = 0;
      int last_cyc = -10;
      bit stalled = 1'b0;
      bit done_seen = 1'b0;
      logic [7:0] prev = 8'h00;
      build_exp(kind, addr, data);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_kind  = kind;
      req_addr  = addr;
      req_data  = data;
      @(negedge clk);
      req_valid = 1'b0;
      while (!done_seen && cyc < 500) begin
         byte_ready = ($urandom % 10) < 7;
         if (poke_busy && cyc == 2) begin
            req_valid = 1'b1;
            req_kind  = ~kind;
            req_addr  = ~addr;
            req_data  = ~data;
         end
         if (poke_busy && cyc == 6) req_valid = 1'b0;
         #1;
         if (stalled)
            check(byte_valid && byte_data == prev, "R12 hold", byte_data, prev);
         if (frame_done) begin
            done_seen = 1'b1;
            check(cnt == FB, "R9 length", cnt, FB);
            check(last_cyc == cyc - 1, "R11 done timing", cyc - last_cyc, 1);
            check(!byte_valid && req_ready, "R11 idle at done",
                  {byte_valid, req_ready}, 2'b01);
         end else if (byte_valid && byte_ready) begin
            if (cnt < FB) got_b[cnt] = byte_data;
            cnt++;
            last_cyc = cyc;
         end
         stalled = byte_valid && !byte_ready;
         prev    = byte_data;
         @(negedge clk);
         cyc++;
      end
      if (!done_seen) check(1'b0, "R11 done missing", 0, 1);
      for (int i = 0; i < FB && i < cnt; i++)
         check(got_b[i] === exp_b[i], tag_of(kind, i), got_b[i], exp_b[i]);
      #1;
      check(!frame_done, "R11 single pulse", frame_done, 0);
      if (poke_busy)
         check(!byte_valid, "R10 no extra frame", byte_valid, 0);
      byte_ready = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_kind = 2'd0;
      req_addr = 5'd0;
      req_data = 16'h0000;
      byte_ready = 1'b0;
      repeat (3) @(negedge clk);
      check(req_ready && !byte_valid && !frame_done, "R1 reset state",
            {req_ready, byte_valid, frame_done}, 3'b100);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready && !byte_valid && !frame_done, "R1 after release",
            {req_ready, byte_valid, frame_done}, 3'b100);

      run_frame(2'd0, 5'd0,  16'h0000, 1'b0);
      run_frame(2'd1, 5'd9,  16'h1234, 1'b0);
      run_frame(2'd2, 5'd0,  16'h0000, 1'b0);
      run_frame(2'd2, 5'd31, 16'h0000, 1'b0);
      run_frame(2'd3, 5'd31, 16'hFFFF, 1'b0);
      run_frame(2'd3, 5'd0,  16'h0000, 1'b0);
      run_frame(2'd3, 5'd2,  16'hA5C3, 1'b1);
      run_frame(2'd0, 5'd0,  16'h0000, 1'b1);

      for (int n = 0; n < 40; n++)
         run_frame(2'($urandom % 4), 5'($urandom % 32), 16'($urandom), 1'($urandom % 4 == 0));

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule